// File: doc/BRIEF.md
# Multi-Lane Substring Match Combiner

This block sits behind W identical byte-lane matchers that each watch one byte lane of a W-byte input word. Each search string is split into W interleaved substrings. Every matcher reports, per cycle, which of the W substrings it has just completed. The block decides from these W×W hit flags whether the whole search string has ended in the stream. The string's final W bytes can land entirely inside one word or be split across two consecutive words.

Each of the W split positions is an alignment. It is checked by ANDing W hit flags. Some flags come from the current word and some from a registered copy of the previous word's flags. The alignment results are registered and ORed into one match flag. The logic depends only on W, never on the strings being searched. Only the lower-triangle hits (lane index greater than substring index) are ever needed from the previous word, so only W(W−1)/2 delay flops exist.

Top module: `mlc_combiner`

## Requirements
- R1: Input bit `x*W + y` of `hit_i` means lane x completed substring y this cycle; x and y run from 0 to W−1.
- R2: Alignment 0 fires when, in one cycle, lane i reports substring i for every i.
- R3: Alignment c (1 ≤ c < W) fires when, for every i ≥ c, lane i−c reports substring i in the current cycle, and, for every i < c, lane i+W−c reported substring i in the cycle directly before.
- R4: Hits are paired only with the immediately preceding cycle; hits two or more cycles old never complete an alignment.
- R5: `match_o` is high exactly when at least one bit of `align_o` is high.
- R6: Outputs are registered. The result for the word presented in cycle n, paired with the word from cycle n−1, appears on `align_o` and `match_o` after the clock edge that ends cycle n.
- R7: While `rst_ni` is low, both outputs are 0. The previous-word state is cleared, so the first word after reset is paired with an all-zero previous word.
- R8: Several alignments may fire in the same cycle, each setting its own bit of `align_o`.
- R9: If any single term of an alignment is missing, that alignment does not fire, even when every other input bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | W*W | Lane/substring hit flags, bit x*W+y |
| align_o | output | W | Registered per-alignment result, bit c for alignment c |
| match_o | output | 1 | Registered full-string match |

## Verification
The hardest case to reach is a string that straddles a reset boundary. The previous word's lower-triangle hits are present and the current word completes alignments 1 to W−1, but reset falls in between. The bench loads exactly that previous word, pulses reset, and then presents the completing word. It expects no alignment to fire, and then shows that the same two-word pair does fire once reset is out of the way. The stimulus table also places a previous-word pattern two cycles ahead of its partner and removes a single term from a full word, to show that stale hits and incomplete alignments stay silent.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  // flat position of lane x, substring y
  function automatic int hit_pos(input int x, input int y, input int w);
    return x * w + y;
  endfunction

  // packed position of a lower-triangle pair (x > y)
  function automatic int tri_pos(input int x, input int y);
    return (x * (x - 1)) / 2 + y;
  endfunction

  function automatic int tri_size(input int w);
    return (w * (w - 1)) / 2;
  endfunction
endpackage

// File: rtl/mlc_delay.sv
module mlc_delay #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/mlc_align_and.sv
module mlc_align_and #(
  parameter int W = 4
) (
  input  logic [W-1:0] terms_i,
  output logic         all_o
);
  assign all_o = &terms_i;
endmodule

// File: rtl/mlc_out_reg.sv
module mlc_out_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] align_d_i,
  output logic [W-1:0] align_o,
  output logic         match_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      align_o <= '0;
      match_o <= 1'b0;
    end else begin
      align_o <= align_d_i;
      match_o <= |align_d_i;
    end
  end
endmodule

// File: rtl/mlc_combiner.sv
module mlc_combiner #(
  parameter int W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W*W-1:0] hit_i,
  output logic [W-1:0]   align_o,
  output logic           match_o
);
  import mlc_pkg::*;

  localparam int NTri = tri_size(W);
  localparam int NTriV = (NTri > 0) ? NTri : 1;

  logic [NTriV-1:0] tri_d;
  logic [NTriV-1:0] tri_q;
  logic [W-1:0]     term [W];
  logic [W-1:0]     align_d;

  // only lane > substring hits are ever used from the previous word
  if (NTri == 0) begin : g_no_tri
    assign tri_d = '0;
  end else begin : g_tri
    for (genvar x = 1; x < W; x++) begin : g_x
      for (genvar y = 0; y < x; y++) begin : g_y
        assign tri_d[tri_pos(x, y)] = hit_i[hit_pos(x, y, W)];
      end
    end
  end

  mlc_delay #(.N(NTriV)) i_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tri_d),
    .q_o   (tri_q)
  );

  for (genvar c = 0; c < W; c++) begin : g_align
    for (genvar i = 0; i < W; i++) begin : g_term
      if (i >= c) begin : g_cur
        assign term[c][i] = hit_i[hit_pos(i - c, i, W)];
      end else begin : g_prev
        assign term[c][i] = tri_q[tri_pos(i + W - c, i)];
      end
    end

    mlc_align_and #(.W(W)) i_and (
      .terms_i(term[c]),
      .all_o  (align_d[c])
    );
  end

  mlc_out_reg #(.W(W)) i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .align_d_i(align_d),
    .align_o  (align_o),
    .match_o  (match_o)
  );
endmodule

// File: rtl/mlc_checker.sv
module mlc_checker #(
  parameter int W = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [W*W-1:0] hit_i,
  input logic [W-1:0]   align_o,
  input logic           match_o
);
  logic [W-1:0] diag;
  for (genvar i = 0; i < W; i++) begin : g_diag
    assign diag[i] = hit_i[i * W + i];
  end

  assert_match_or_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o == (|align_o));

  assert_diag_fires_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&diag) |=> align_o[0]);

  assert_diag_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_o[0] |-> $past(&diag));

  assert_last_cur_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_o[W-1] |-> $past(hit_i[W-1]));

  if (W > 1) begin : g_straddle
    assert_prev_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      align_o[1] |-> $past(hit_i[(W-1) * W], 2));
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R7: assert (!match_o && align_o == '0);
    end
  end
endmodule

bind mlc_combiner mlc_checker #(.W(W)) i_mlc_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .hit_i  (hit_i),
  .align_o(align_o),
  .match_o(match_o)
);

// File: tb/test_mlc_combiner.sv
`timescale 1ns/1ps
module test_mlc_combiner;
  localparam int W = 4;
  localparam int NV = 15;

  // bit x*4+y = lane x hit substring y (R1)
  // alignment 0 current: 8421; 1: cur 0842 prev 1000;
  // 2: cur 0084 prev 2100; 3: cur 0008 prev 4210
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'h8421, 16'h1000, 16'h0842, 16'h2100,
    16'h0084, 16'h4210, 16'h0008, 16'h0842, 16'hFFFF,
    16'hFFFF, 16'h8420, 16'h7310, 16'h08CE, 16'h0000
  };
  localparam logic [3:0] EXP [NV] = '{
    4'b0000, 4'b0001, 4'b0000, 4'b0010, 4'b0000,
    4'b0100, 4'b0000, 4'b1000, 4'b0000, 4'b0001,
    4'b1111, 4'b0000, 4'b0000, 4'b1110, 4'b0000
  };

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [W*W-1:0] hit_i = '0;
  logic [W-1:0]   align_o;
  logic           match_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mlc_combiner #(.W(W)) i_mlc_combiner (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_i),
    .align_o(align_o),
    .match_o(match_o)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic [15:0] v);
    @(negedge clk_i);
    hit_i = v;
    @(posedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    hit_i = 16'hFFFF;
    repeat (3) @(posedge clk_i);
    #1;
    // R7: outputs held at 0 during reset even with every hit set
    check("R7 reset align", align_o, 4'b0000);
    check("R7 reset match", {3'b000, match_o}, 4'b0000);
    @(negedge clk_i);
    hit_i = '0;
    rst_ni = 1'b1;

    // table walk: R1 R2 R3 R4 R8 R9, match via R5, latency R6
    for (int k = 0; k < NV; k++) begin
      step(VEC[k]);
      check($sformatf("R3/R6 vec %0d align", k), align_o, EXP[k]);
      check($sformatf("R5 vec %0d match", k), {3'b000, match_o}, {3'b000, |EXP[k]});
    end

    // R6: result not visible before the edge that ends the cycle
    step(16'h8421);
    @(negedge clk_i);
    hit_i = 16'h0000;
    #0.5;
    check("R6 hold until edge", align_o, 4'b0001);
    @(posedge clk_i);
    #1;
    check("R6 cleared after edge", align_o, 4'b0000);

    // R7: previous-word state cleared by reset
    step(16'h7310);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5;
    check("R7 async clear", align_o, 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    hit_i = 16'h08CE;
    @(posedge clk_i);
    #1;
    check("R7 prev zero after reset", align_o, 4'b0000);
    step(16'h7310);
    step(16'h08CE);
    // R8: three alignments at once after recovery
    check("R8 multi after reset", align_o, 4'b1110);
    check("R5 multi match", {3'b000, match_o}, 4'b0001);

    // R4: previous pattern two cycles back does not count
    step(16'h1000);
    step(16'h0000);
    step(16'h0842);
    check("R4 stale prev", align_o, 4'b0000);

    // R9: one term missing from alignment 3 (prev bit 9)
    step(16'h4010);
    step(16'h0008);
    check("R9 missing term", align_o, 4'b0000);

    // R2: diagonal with unrelated extra hits still fires alignment 0
    step(16'h0000);
    step(16'h8421 | 16'h0030);
    check("R2 diag with extras", align_o, 4'b0001);

    done = 1'b1;
    finish_run();
  end
endmodule